// File: doc/BRIEF.md
# UART Receive Address-Match Filter

This block sits on the path from a UART receiver's character output to the receive data buffer and implements multidrop addressing. A received character with its most significant bit set counts as an address. It is compared against two programmable match values, and each comparison has its own enable. A matching address opens the path for the data characters that follow. A failed match closes it, and those data characters are dropped.

Software programs the two match values and the two enables through a small synchronous register port. A smart-card mode input, when high, overrides both enables. The receiver presents each character with a one-cycle valid strobe. Every character that is passed appears at the output exactly one clock later, with its own one-cycle strobe.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, outValid is low and the two match values and both enables read back as zero.
- R2: Register offset 0 holds match value A and offset 1 holds match value B, both 8 bits and readable at any time. Offset 2 is the control register, with enable A in bit 7 and enable B in bit 6; its other bits read 0. Offset 3 reads 0. A write lands on the clock edge where regWrEn is high.
- R3: While both effective enables are clear, every received character is forwarded unchanged.
- R4: When match mode is on, an address character (bit 7 set) that equals an enabled match value is forwarded. The data characters (bit 7 clear) that follow it are forwarded until the next address character.
- R5: An address character that matches no enabled match value is dropped.
- R6: Either comparator alone is enough for a match. A comparator whose enable is clear never matches, even when its match value equals the character.
- R7: When match mode is on, a data character is dropped unless the most recent address character matched.
- R8: While smartCardEn is high, both enables act as clear: all characters pass and the match state is cleared. The stored enable bits still read back as written.
- R9: Clearing both enables clears the match state. After match mode is enabled again, data is dropped until a new address character matches.
- R10: outValid is a one-cycle pulse. It is raised only in the cycle after an rxValid cycle whose character was passed, and outChar then carries that character.
- R11: A register write in the same cycle as rxValid does not affect the decision for that character. It applies from the next character on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| smartCardEn | input | 1 | Forces both match enables inactive |
| rxValid | input | 1 | Received character strobe |
| rxChar | input | 8 | Received character |
| outValid | output | 1 | Forwarded character strobe |
| outChar | output | 8 | Forwarded character |

## Verification
The only hidden state is the sticky match flag. A wrong flag shows up at the first data character after the address or enable event that should have set or cleared it: outValid on the following cycle is present when it should be absent, or absent when it should be present. Wrong comparator or enable wiring shows on the address character itself, one cycle after its strobe. A register that decodes or resets wrongly is visible at once on regRdData. The sweeps send every 8-bit value, each followed by a data character, under every combination of the enables and smart-card mode. A wrong flag is therefore seen within one character.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic emit;     // forward the current character
    logic armed;    // sticky match state, for observation
  } rxfCtl_t;
endpackage

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int ADDR_W = 2,
  parameter int NUM_CMP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CHAR_W-1:0] regWrData,
  output logic [CHAR_W-1:0] regRdData,
  input  logic              smartCardEn,
  input  logic [CHAR_W-1:0] rxChar,
  input  rxfCtl_t           ctl,
  output logic              isAddr,
  output logic              anyEn,
  output logic              hit,
  output logic              outValid,
  output logic [CHAR_W-1:0] outChar,
  output logic [CHAR_W-1:0] matchA,
  output logic [CHAR_W-1:0] matchB,
  output logic              enA,
  output logic              enB
);
  localparam int MSB = CHAR_W - 1;
  localparam logic [ADDR_W-1:0] CTL_OFS = ADDR_W'(NUM_CMP);

  logic [CHAR_W-1:0] matchReg [NUM_CMP];
  logic [NUM_CMP-1:0] enReg;
  logic [NUM_CMP-1:0] enEff;
  logic [NUM_CMP-1:0] hitVec;

  // one match register, enable and comparator per slot;
  // enable i sits at control bit MSB-i
  for (genvar i = 0; i < NUM_CMP; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        matchReg[i] <= '0;
        enReg[i]    <= 1'b0;
      end else if (regWrEn) begin
        if (regAddr == ADDR_W'(i)) matchReg[i] <= regWrData;
        if (regAddr == CTL_OFS)    enReg[i]    <= regWrData[MSB-i];
      end
    end
    assign enEff[i]  = enReg[i] & ~smartCardEn;
    assign hitVec[i] = enEff[i] && (rxChar == matchReg[i]);
  end

  assign isAddr = rxChar[MSB];
  assign anyEn  = |enEff;
  assign hit    = |hitVec;

  always_comb begin
    regRdData = '0;
    if (regAddr == CTL_OFS) begin
      for (int i = 0; i < NUM_CMP; i++) regRdData[MSB-i] = enReg[i];
    end else begin
      for (int i = 0; i < NUM_CMP; i++)
        if (regAddr == ADDR_W'(i)) regRdData = matchReg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outChar  <= '0;
    end else begin
      outValid <= ctl.emit;
      if (ctl.emit) outChar <= rxChar;
    end
  end

  assign matchA = matchReg[0];
  assign matchB = matchReg[1];
  assign enA    = enReg[0];
  assign enB    = enReg[1];
endmodule

// File: rtl/rxf_control.sv
module rxf_control
  import rxf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxValid,
  input  logic    isAddr,
  input  logic    anyEn,
  input  logic    hit,
  output rxfCtl_t ctl
);
  logic armedQ;

  // sticky match state: follows each address character, cleared when filtering is off
  always_ff @(posedge clk) begin
    if (!rstN)                  armedQ <= 1'b0;
    else if (!anyEn)            armedQ <= 1'b0;
    else if (rxValid && isAddr) armedQ <= hit;
  end

  always_comb begin
    ctl.armed = armedQ;
    if (!rxValid)     ctl.emit = 1'b0;
    else if (!anyEn)  ctl.emit = 1'b1;
    else if (isAddr)  ctl.emit = hit;
    else              ctl.emit = armedQ;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CHAR_W-1:0] regWrData,
  output logic [CHAR_W-1:0] regRdData,
  input  logic              smartCardEn,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  output logic              outValid,
  output logic [CHAR_W-1:0] outChar
);
  rxfCtl_t ctl;
  logic isAddr, anyEn, hit;
  logic [CHAR_W-1:0] matchA, matchB;
  logic enA, enB, armed;

  rxf_datapath #(.CHAR_W(CHAR_W), .ADDR_W(ADDR_W), .NUM_CMP(2)) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .smartCardEn(smartCardEn),
    .rxChar(rxChar), .ctl(ctl), .isAddr(isAddr), .anyEn(anyEn), .hit(hit),
    .outValid(outValid), .outChar(outChar), .matchA(matchA), .matchB(matchB),
    .enA(enA), .enB(enB)
  );

  rxf_control uCtl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .isAddr(isAddr),
    .anyEn(anyEn), .hit(hit), .ctl(ctl)
  );

  assign armed = ctl.armed;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int CHAR_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CHAR_W-1:0] regWrData,
  input logic              smartCardEn,
  input logic              rxValid,
  input logic [CHAR_W-1:0] rxChar,
  input logic              outValid,
  input logic [CHAR_W-1:0] outChar,
  input logic [CHAR_W-1:0] matchA,
  input logic [CHAR_W-1:0] matchB,
  input logic              enA,
  input logic              enB,
  input logic              armed
);
  logic onA, onB, on, addrHit;
  assign onA = enA && !smartCardEn;
  assign onB = enB && !smartCardEn;
  assign on  = onA || onB;
  assign addrHit = (onA && rxChar == matchA) || (onB && rxChar == matchB);

  assert_match_a_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 2'd0 |=> matchA == $past(regWrData));

  assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !on |=> outValid && outChar == $past(rxChar));

  assert_addr_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxChar[CHAR_W-1] && addrHit |=> outValid && armed);

  assert_addr_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && on && rxChar[CHAR_W-1] && !addrHit |=> !outValid && !armed);

  assert_data_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && on && !rxChar[CHAR_W-1] && !armed |=> !outValid);

  assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !on |=> !armed);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !outValid);
endmodule

bind rx_addr_filter rxf_checker #(.CHAR_W(CHAR_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .smartCardEn(smartCardEn), .rxValid(rxValid),
  .rxChar(rxChar), .outValid(outValid), .outChar(outChar), .matchA(matchA),
  .matchB(matchB), .enA(enA), .enB(enB), .armed(armed)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic smartCardEn = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxChar = '0;
  logic outValid;
  logic [7:0] outChar;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // bench model of the programmed state
  logic [7:0] mA = '0, mB = '0;
  bit eA = 0, eB = 0, sc = 0, matched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .smartCardEn(smartCardEn),
    .rxValid(rxValid), .rxChar(rxChar), .outValid(outValid), .outChar(outChar)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit modelOn();
    return (eA || eB) && !sc;
  endfunction

  task automatic applyWrite(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: mA = d;
      2'd1: mB = d;
      2'd2: begin eA = d[7]; eB = d[6]; end
      default: ;
    endcase
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    applyWrite(a, d);
    if (!modelOn()) matched = 0;
  endtask

  task automatic setSc(input bit v);
    @(negedge clk);
    smartCardEn = v; sc = v;
    @(negedge clk);
    if (!modelOn()) matched = 0;
  endtask

  task automatic readReg(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 check(req, regRdData, exp);
  endtask

  // expected decision from the requirements, then drive and compare
  task automatic sendChar(input logic [7:0] c, input string tag,
                          input bit withWr, input logic [1:0] wa, input logic [7:0] wd);
    bit pass, hitNow;
    string req;
    if (!modelOn()) begin
      pass = 1; matched = 0; req = sc ? "R8" : "R3";
    end else if (c[7]) begin
      hitNow = (eA && c == mA) || (eB && c == mB);
      pass = hitNow; matched = hitNow; req = hitNow ? "R4" : "R5";
    end else begin
      pass = matched; req = matched ? "R4" : "R7";
    end
    if (tag != "") req = tag;
    @(negedge clk);
    rxValid = 1'b1; rxChar = c;
    if (withWr) begin regWrEn = 1'b1; regAddr = wa; regWrData = wd; end
    @(negedge clk);
    rxValid = 1'b0; regWrEn = 1'b0;
    if (withWr) begin
      applyWrite(wa, wd);
      if (!modelOn()) matched = 0;
    end
    check(req, outValid, pass);
    if (pass) check(req, outChar, c);
    @(negedge clk);
    check("R10", outValid, 0);
  endtask

  task automatic send(input logic [7:0] c, input string tag);
    sendChar(c, tag, 1'b0, 2'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", outValid, 0);
    readReg("R1", 2'd0, 8'h00);
    readReg("R1", 2'd1, 8'h00);
    readReg("R1", 2'd2, 8'h00);

    // R2: register map
    writeReg(2'd0, 8'h85); readReg("R2", 2'd0, 8'h85);
    writeReg(2'd1, 8'hA3); readReg("R2", 2'd1, 8'hA3);
    writeReg(2'd2, 8'hFF); readReg("R2", 2'd2, 8'hC0);
    readReg("R2", 2'd3, 8'h00);
    writeReg(2'd2, 8'h40); readReg("R2", 2'd2, 8'h40);
    writeReg(2'd2, 8'h00); readReg("R2", 2'd2, 8'h00);

    // sweep all enable / smart-card combinations over every character value
    for (int cfg = 0; cfg < 8; cfg++) begin
      setSc(cfg[2]);
      writeReg(2'd2, {cfg[0] ? 1'b1 : 1'b0, cfg[1] ? 1'b1 : 1'b0, 6'h00});
      if (cfg[2]) readReg("R8", 2'd2, {cfg[0] ? 1'b1 : 1'b0, cfg[1] ? 1'b1 : 1'b0, 6'h00});
      for (int c = 0; c < 256; c++) begin
        send(8'(c), "");
        send(8'h11, "");
      end
    end
    setSc(1'b0);

    // R6: disabled comparator never matches, either one suffices
    writeReg(2'd2, 8'h80);
    send(8'hA3, "R6");
    send(8'h22, "R6");
    send(8'h85, "R6");
    writeReg(2'd2, 8'h40);
    send(8'h85, "R6");
    send(8'hA3, "R6");
    send(8'h33, "R6");

    // R8: smart-card mode clears the match state
    writeReg(2'd2, 8'hC0);
    send(8'h85, "R8");
    setSc(1'b1);
    send(8'h44, "R8");
    setSc(1'b0);
    send(8'h45, "R8");

    // R9: disabling both enables clears the match state
    send(8'h85, "R9");
    writeReg(2'd2, 8'h00);
    writeReg(2'd2, 8'h80);
    send(8'h12, "R9");
    send(8'h85, "R9");
    send(8'h13, "R9");

    // R11: write in the same cycle as a character applies to the next one
    writeReg(2'd0, 8'h90);
    writeReg(2'd2, 8'h80);
    sendChar(8'h85, "R11", 1'b1, 2'd0, 8'h85);
    send(8'h85, "R11");
    sendChar(8'h14, "R11", 1'b1, 2'd2, 8'h00);
    send(8'h92, "R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule